// File: doc/BRIEF.md
# Microprocessor system bus controller

This block sits between an 8-bit microprocessor and the memory and I/O devices on its system bus. At the start of every machine cycle the CPU places a status byte on its data bus and pulses a status strobe low. The block captures that byte into a status register. For the rest of the cycle it combines the captured status with the CPU's data-bus-in strobe, its write strobe and its hold-acknowledge to produce five active-low command strobes: memory read, memory write, I/O read, I/O write and interrupt acknowledge.

The block also steers the bidirectional data buffer between the CPU side and the system side. The buffer is modelled as separate input, output and output-enable signals on each side. When the bus-enable input is high, or the CPU grants the bus for DMA, the system-side data drivers and the command strobes float immediately, with no clock involved. A static option input selects a single-vector interrupt mode. In that mode the block places the restart-7 opcode on the CPU side whenever data is read during an interrupt-acknowledge cycle, so no interrupt instruction port is needed.

Top module: `sysbus_ctrl`

## Requirements
- R1: The status register loads `cpu_d_in` on each rising clock edge at which `sts_stb_n` is 0, and holds its value on edges at which `sts_stb_n` is 1. Synchronous reset sets it to 8'h02, in which no command is active. The status bits are: bit 7 memory read, bit 6 input, bit 5 opcode fetch, bit 4 output, bit 3 halt acknowledge, bit 2 stack, bit 1 write/output (active low), bit 0 interrupt acknowledge.
- R2: With the bus not floated, the read commands follow `dbin`. `memr_n` is 0 exactly when status bit 7 is 1 and `dbin` is 1. `ior_n` is 0 exactly when bit 6 is 1 and `dbin` is 1. `inta_n` is 0 exactly when bit 0 is 1 and `dbin` is 1.
- R3: With the bus not floated, the write commands follow `wr_n`. `memw_n` is 0 exactly when `wr_n` is 0 and status bits 1 and 4 are both 0. `iow_n` is 0 exactly when `wr_n` is 0, bit 1 is 0 and bit 4 is 1.
- R4: All five command outputs are active low. After reset they all read 1 and `ctl_oe` is 1.
- R5: While `bus_en_n` is 1, `ctl_oe` and `sys_d_oe` are 0 and all five commands read 1, in the same cycle, without waiting for a clock edge.
- R6: While `hlda` is 1, the outputs float exactly as in R5.
- R7: With the bus not floated and `sts_stb_n` at 1, the buffer drives the CPU side (`cpu_d_oe`=1, `cpu_d_out`=`sys_d_in`) while `dbin` is 1, and drives the system side (`sys_d_oe`=1, `sys_d_out`=`cpu_d_in`) while `dbin` is 0. While `sts_stb_n` is 0, neither side is driven, and the two enables are never both 1.
- R8: While `rst7_en` is 1, the latched status bit 0 is 1, `dbin` is 1 and `sts_stb_n` is 1, the block drives 8'hFF on `cpu_d_out` with `cpu_d_oe`=1. This holds whatever `sys_d_in` is, and even while the bus is floated.
- R9: A three-byte call supplied as the interrupt instruction is fetched in three successive acknowledge cycles. Each cycle gives its own `inta_n` pulse. With the option off, each byte passes from `sys_d_in` to `cpu_d_out`; with the option on, each read returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sts_stb_n | input | 1 | Status strobe from CPU, active low |
| dbin | input | 1 | CPU data-bus-in strobe, active high |
| wr_n | input | 1 | CPU write strobe, active low |
| hlda | input | 1 | CPU hold acknowledge (DMA), active high |
| bus_en_n | input | 1 | Bus enable; 1 floats system-side outputs |
| rst7_en | input | 1 | Static single-vector restart option |
| cpu_d_in | input | 8 | Data driven by the CPU |
| cpu_d_out | output | 8 | Data driven toward the CPU |
| cpu_d_oe | output | 1 | Drive enable toward the CPU |
| sys_d_in | input | 8 | Data from the system bus |
| sys_d_out | output | 8 | Data driven onto the system bus |
| sys_d_oe | output | 1 | Drive enable onto the system bus |
| memr_n | output | 1 | Memory read command, active low |
| memw_n | output | 1 | Memory write command, active low |
| ior_n | output | 1 | I/O read command, active low |
| iow_n | output | 1 | I/O write command, active low |
| inta_n | output | 1 | Interrupt acknowledge command, active low |
| ctl_oe | output | 1 | Command strobe drive enable |

## Verification
Ten status words cover each cycle type: fetch, memory read, memory write, stack read and write, input, output, interrupt acknowledge, halt, and acknowledge during halt. Each word is latched and then tried under all sixteen settings of data-bus-in, write, hold-acknowledge and bus-enable. This separates commands that wrongly decode status bits from ones that ignore their qualifying strobe, and from outputs that fail to float under either float source. Directed sequences then separate capture from hold in the status register and show that data steering is blocked during the strobe. They also show restart insertion against pass-through with the option on and off, including while floated and across a three-byte call.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    localparam int DATA_W = 8;

    // status bit positions
    localparam int ST_ACK   = 0;
    localparam int ST_WO_N  = 1;
    localparam int ST_STACK = 2;
    localparam int ST_HALT  = 3;
    localparam int ST_OUT   = 4;
    localparam int ST_FETCH = 5;
    localparam int ST_INP   = 6;
    localparam int ST_MRD   = 7;

    localparam logic [DATA_W-1:0] ST_IDLE   = 8'h02;
    localparam logic [DATA_W-1:0] RST7_CODE = 8'hFF;

    typedef struct packed {
        logic mem_rd;
        logic inp;
        logic fetch;
        logic outp;
        logic halt;
        logic stack;
        logic wo_n;
        logic ack;
    } status_t;

    // active-high command request set, in output order
    localparam int N_CMD = 5;
    typedef enum logic [2:0] {
        CMD_MEMR = 3'd0,
        CMD_MEMW = 3'd1,
        CMD_IOR  = 3'd2,
        CMD_IOW  = 3'd3,
        CMD_INTA = 3'd4
    } cmd_e;

    typedef enum logic {
        QUAL_READ  = 1'b0,
        QUAL_WRITE = 1'b1
    } qual_e;

    // which CPU strobe qualifies each command
    function automatic qual_e cmd_qual(input int idx);
        return (idx == int'(CMD_MEMW) || idx == int'(CMD_IOW)) ? QUAL_WRITE : QUAL_READ;
    endfunction

    // status-only part of each command decode
    function automatic logic [N_CMD-1:0] cmd_select(input status_t st);
        logic [N_CMD-1:0] sel;
        sel              = '0;
        sel[CMD_MEMR]    = st.mem_rd;
        sel[CMD_IOR]     = st.inp;
        sel[CMD_INTA]    = st.ack;
        sel[CMD_MEMW]    = ~st.wo_n & ~st.outp;
        sel[CMD_IOW]     = ~st.wo_n &  st.outp;
        return sel;
    endfunction

    typedef enum logic [1:0] {
        DIR_NONE  = 2'd0,
        DIR_TOCPU = 2'd1,
        DIR_TOSYS = 2'd2
    } dir_e;

endpackage

// File: rtl/sbc_status_reg.sv
module sbc_status_reg
    import sbc_pkg::*;
#(
    parameter int                 W         = DATA_W,
    parameter logic [W-1:0]       RESET_VAL = ST_IDLE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         stb_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RESET_VAL;
        end else if (!stb_n) begin
            q <= d;
        end
    end

endmodule

// File: rtl/sbc_cmd_gen.sv
module sbc_cmd_gen
    import sbc_pkg::*;
(
    input  status_t          st,
    input  logic             dbin,
    input  logic             wr_n,
    input  logic             float_req,
    output logic [N_CMD-1:0] cmd_n,
    output logic             ctl_oe
);

    logic [N_CMD-1:0] sel;

    always_comb begin
        sel = cmd_select(st);
    end

    for (genvar g = 0; g < N_CMD; g++) begin : g_cmd
        logic qual;
        if (cmd_qual(g) == QUAL_WRITE) begin : g_wr
            assign qual = ~wr_n;
        end else begin : g_rd
            assign qual = dbin;
        end
        assign cmd_n[g] = ~(sel[g] & qual & ~float_req);
    end

    assign ctl_oe = ~float_req;

endmodule

// File: rtl/sbc_data_steer.sv
module sbc_data_steer
    import sbc_pkg::*;
#(
    parameter int           W       = DATA_W,
    parameter logic [W-1:0] INS_OP  = RST7_CODE
) (
    input  logic         dbin,
    input  logic         stb_n,
    input  logic         float_req,
    input  logic         ack_cycle,
    input  logic         ins_en,
    input  logic [W-1:0] cpu_d_in,
    input  logic [W-1:0] sys_d_in,
    output logic [W-1:0] cpu_d_out,
    output logic         cpu_d_oe,
    output logic [W-1:0] sys_d_out,
    output logic         sys_d_oe
);

    dir_e dir;
    logic insert;

    always_comb begin
        insert = ins_en & ack_cycle & dbin & stb_n;
        if (!stb_n) begin
            dir = DIR_NONE;
        end else if (insert) begin
            dir = DIR_TOCPU;
        end else if (float_req) begin
            dir = DIR_NONE;
        end else if (dbin) begin
            dir = DIR_TOCPU;
        end else begin
            dir = DIR_TOSYS;
        end
    end

    assign cpu_d_oe  = (dir == DIR_TOCPU);
    assign sys_d_oe  = (dir == DIR_TOSYS);
    assign cpu_d_out = insert ? INS_OP : sys_d_in;
    assign sys_d_out = cpu_d_in;

endmodule

// File: rtl/sysbus_ctrl.sv
module sysbus_ctrl
    import sbc_pkg::*;
#(
    parameter int                W       = DATA_W,
    parameter logic [W-1:0]      RST_VAL = ST_IDLE,
    parameter logic [W-1:0]      INS_OP  = RST7_CODE
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sts_stb_n,
    input  logic         dbin,
    input  logic         wr_n,
    input  logic         hlda,
    input  logic         bus_en_n,
    input  logic         rst7_en,
    input  logic [W-1:0] cpu_d_in,
    output logic [W-1:0] cpu_d_out,
    output logic         cpu_d_oe,
    input  logic [W-1:0] sys_d_in,
    output logic [W-1:0] sys_d_out,
    output logic         sys_d_oe,
    output logic         memr_n,
    output logic         memw_n,
    output logic         ior_n,
    output logic         iow_n,
    output logic         inta_n,
    output logic         ctl_oe
);

    logic [W-1:0]     stat_q;
    status_t          st;
    logic             float_req;
    logic [N_CMD-1:0] cmd_n;

    assign float_req = bus_en_n | hlda;
    assign st        = status_t'(stat_q[DATA_W-1:0]);

    sbc_status_reg #(.W(W), .RESET_VAL(RST_VAL)) u_stat (
        .clk   (clk),
        .rst   (rst),
        .stb_n (sts_stb_n),
        .d     (cpu_d_in),
        .q     (stat_q)
    );

    sbc_cmd_gen u_cmd (
        .st        (st),
        .dbin      (dbin),
        .wr_n      (wr_n),
        .float_req (float_req),
        .cmd_n     (cmd_n),
        .ctl_oe    (ctl_oe)
    );

    sbc_data_steer #(.W(W), .INS_OP(INS_OP)) u_steer (
        .dbin      (dbin),
        .stb_n     (sts_stb_n),
        .float_req (float_req),
        .ack_cycle (st.ack),
        .ins_en    (rst7_en),
        .cpu_d_in  (cpu_d_in),
        .sys_d_in  (sys_d_in),
        .cpu_d_out (cpu_d_out),
        .cpu_d_oe  (cpu_d_oe),
        .sys_d_out (sys_d_out),
        .sys_d_oe  (sys_d_oe)
    );

    assign memr_n = cmd_n[CMD_MEMR];
    assign memw_n = cmd_n[CMD_MEMW];
    assign ior_n  = cmd_n[CMD_IOR];
    assign iow_n  = cmd_n[CMD_IOW];
    assign inta_n = cmd_n[CMD_INTA];

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         sts_stb_n,
    input logic         dbin,
    input logic         wr_n,
    input logic         hlda,
    input logic         bus_en_n,
    input logic         rst7_en,
    input logic [W-1:0] cpu_d_in,
    input logic [W-1:0] stat_q,
    input logic [W-1:0] cpu_d_out,
    input logic         cpu_d_oe,
    input logic         sys_d_oe,
    input logic         memr_n,
    input logic         memw_n,
    input logic         ior_n,
    input logic         iow_n,
    input logic         inta_n,
    input logic         ctl_oe
);

    p_capture_r1: assert property (@(posedge clk) disable iff (rst)
        !sts_stb_n |=> stat_q == $past(cpu_d_in));

    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        sts_stb_n |=> $stable(stat_q));

    p_read_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !dbin |-> (memr_n && ior_n && inta_n));

    p_write_idle_r3: assert property (@(posedge clk) disable iff (rst)
        wr_n |-> (memw_n && iow_n));

    p_busen_float_r5: assert property (@(posedge clk) disable iff (rst)
        bus_en_n |-> (!ctl_oe && !sys_d_oe && memr_n && memw_n && ior_n && iow_n && inta_n));

    p_dma_float_r6: assert property (@(posedge clk) disable iff (rst)
        hlda |-> (!ctl_oe && !sys_d_oe));

    p_one_dir_r7: assert property (@(posedge clk) disable iff (rst)
        !(cpu_d_oe && sys_d_oe));

    p_strobe_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        !sts_stb_n |-> (!cpu_d_oe && !sys_d_oe));

    p_insert_r8: assert property (@(posedge clk) disable iff (rst)
        (rst7_en && dbin && sts_stb_n && stat_q[0]) |-> (cpu_d_oe && cpu_d_out == {W{1'b1}}));

endmodule

bind sysbus_ctrl sbc_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sts_stb_n (sts_stb_n),
    .dbin      (dbin),
    .wr_n      (wr_n),
    .hlda      (hlda),
    .bus_en_n  (bus_en_n),
    .rst7_en   (rst7_en),
    .cpu_d_in  (cpu_d_in),
    .stat_q    (stat_q),
    .cpu_d_out (cpu_d_out),
    .cpu_d_oe  (cpu_d_oe),
    .sys_d_oe  (sys_d_oe),
    .memr_n    (memr_n),
    .memw_n    (memw_n),
    .ior_n     (ior_n),
    .iow_n     (iow_n),
    .inta_n    (inta_n),
    .ctl_oe    (ctl_oe)
);

// File: tb/sim_sysbus_ctrl.sv
`timescale 1ns/1ps
module sim_sysbus_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sts_stb_n = 1'b1;
    logic       dbin = 1'b0;
    logic       wr_n = 1'b1;
    logic       hlda = 1'b0;
    logic       bus_en_n = 1'b0;
    logic       rst7_en = 1'b0;
    logic [7:0] cpu_d_in = 8'h00;
    logic [7:0] sys_d_in = 8'h00;
    logic [7:0] cpu_d_out, sys_d_out;
    logic       cpu_d_oe, sys_d_oe;
    logic       memr_n, memw_n, ior_n, iow_n, inta_n, ctl_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    sysbus_ctrl u0 (
        .clk(clk), .rst(rst), .sts_stb_n(sts_stb_n), .dbin(dbin), .wr_n(wr_n),
        .hlda(hlda), .bus_en_n(bus_en_n), .rst7_en(rst7_en),
        .cpu_d_in(cpu_d_in), .cpu_d_out(cpu_d_out), .cpu_d_oe(cpu_d_oe),
        .sys_d_in(sys_d_in), .sys_d_out(sys_d_out), .sys_d_oe(sys_d_oe),
        .memr_n(memr_n), .memw_n(memw_n), .ior_n(ior_n), .iow_n(iow_n),
        .inta_n(inta_n), .ctl_oe(ctl_oe)
    );

    // {status, read set {memr,ior,inta}, write set {memw,iow}}
    localparam logic [12:0] VEC [10] = '{
        {8'hA2, 3'b100, 2'b00},  // opcode fetch
        {8'h82, 3'b100, 2'b00},  // memory read
        {8'h00, 3'b000, 2'b10},  // memory write
        {8'h86, 3'b100, 2'b00},  // stack read
        {8'h04, 3'b000, 2'b10},  // stack write
        {8'h42, 3'b010, 2'b00},  // input
        {8'h10, 3'b000, 2'b01},  // output
        {8'h23, 3'b001, 2'b00},  // interrupt acknowledge
        {8'h8A, 3'b100, 2'b00},  // halt acknowledge
        {8'h2B, 3'b001, 2'b00}   // acknowledge while halted
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic latch(input logic [7:0] s);
        @(negedge clk);
        cpu_d_in  = s;
        sts_stb_n = 1'b0;
        dbin      = 1'b0;
        wr_n      = 1'b1;
        @(negedge clk);
        sts_stb_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R4: reset state
        chk("R4 reset strobes", {memr_n, memw_n, ior_n, iow_n, inta_n, ctl_oe}, 6'b111111);
        dbin = 1'b1; wr_n = 1'b0; #1;
        chk("R1 R4 idle status after reset", {memr_n, memw_n, ior_n, iow_n, inta_n}, 5'b11111);
        dbin = 1'b0; wr_n = 1'b1;

        // table: every status type against all strobe and float settings
        for (int i = 0; i < 10; i++) begin
            latch(VEC[i][12:5]);
            for (int c = 0; c < 16; c++) begin
                logic fl;
                logic [2:0] rd;
                logic [1:0] wv;
                logic [7:0] exp;
                dbin     = c[0];
                wr_n     = c[1];
                hlda     = c[2];
                bus_en_n = c[3];
                #1;
                fl = hlda | bus_en_n;
                rd = VEC[i][4:2];
                wv = VEC[i][1:0];
                exp = {~(rd[2] & dbin & ~fl), ~(wv[1] & ~wr_n & ~fl),
                       ~(rd[1] & dbin & ~fl), ~(wv[0] & ~wr_n & ~fl),
                       ~(rd[0] & dbin & ~fl), ~fl, ~dbin & ~fl, dbin & ~fl};
                chk("R2 R3 R5 R6 R7 decode table",
                    {memr_n, memw_n, ior_n, iow_n, inta_n, ctl_oe, sys_d_oe, cpu_d_oe}, exp);
            end
            hlda = 1'b0; bus_en_n = 1'b0; dbin = 1'b0; wr_n = 1'b1;
        end

        // R1: hold while strobe high
        latch(8'h82);
        cpu_d_in = 8'h10;
        @(negedge clk); @(negedge clk);
        dbin = 1'b1; #1;
        chk("R1 status held", {memr_n, ior_n}, 2'b01);
        dbin = 1'b0; wr_n = 1'b0; #1;
        chk("R1 held status ignores new bus", {memw_n, iow_n}, 2'b11);
        wr_n = 1'b1;

        // R7: no drive during status strobe
        @(negedge clk);
        sts_stb_n = 1'b0; dbin = 1'b1; #1;
        chk("R7 quiet during strobe", {cpu_d_oe, sys_d_oe}, 2'b00);
        dbin = 1'b0; #1;
        chk("R7 quiet during strobe wr side", {cpu_d_oe, sys_d_oe}, 2'b00);
        @(negedge clk);
        sts_stb_n = 1'b1;

        // R7: data paths
        latch(8'h82);
        sys_d_in = 8'h5A; dbin = 1'b1; #1;
        chk("R7 sys to cpu", {cpu_d_oe, cpu_d_out}, {1'b1, 8'h5A});
        dbin = 1'b0; cpu_d_in = 8'hC3; #1;
        chk("R7 cpu to sys", {sys_d_oe, sys_d_out}, {1'b1, 8'hC3});

        // R8: restart insertion
        rst7_en = 1'b1;
        latch(8'h23);
        sys_d_in = 8'h12; dbin = 1'b1; #1;
        chk("R8 insert on", {cpu_d_oe, cpu_d_out, inta_n}, {1'b1, 8'hFF, 1'b0});
        bus_en_n = 1'b1; #1;
        chk("R8 insert while floated", {cpu_d_oe, cpu_d_out, sys_d_oe}, {1'b1, 8'hFF, 1'b0});
        bus_en_n = 1'b0; dbin = 1'b0;
        latch(8'h82);
        dbin = 1'b1; #1;
        chk("R8 no insert outside ack", cpu_d_out, 8'h12);
        dbin = 1'b0;
        rst7_en = 1'b0;
        latch(8'h23);
        dbin = 1'b1; #1;
        chk("R8 insert off", {cpu_d_oe, cpu_d_out}, {1'b1, 8'h12});
        dbin = 1'b0;

        // R9: three-byte call, option off then on
        for (int opt = 0; opt < 2; opt++) begin
            rst7_en = opt[0];
            for (int b = 0; b < 3; b++) begin
                logic [7:0] byt;
                byt = (b == 0) ? 8'hCD : (b == 1) ? 8'h34 : 8'h12;
                latch(8'h23);
                sys_d_in = byt; #1;
                chk("R9 call ack idle", inta_n, 1'b1);
                dbin = 1'b1; #1;
                chk("R9 call ack pulse", {inta_n, cpu_d_out}, {1'b0, opt[0] ? 8'hFF : byt});
                @(negedge clk);
                dbin = 1'b0; #1;
                chk("R9 call ack end", inta_n, 1'b1);
            end
        end
        rst7_en = 1'b0;

        // R1 R4: reset returns to idle
        latch(8'h82);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0; dbin = 1'b1; #1;
        chk("R1 R4 reset clears status", memr_n, 1'b1);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule